// File: doc/BRIEF.md
# Split-Mode Event Counter Bank

This block holds four 32-bit physical event counters behind a small register interface with word addresses. Each physical counter runs either as one 32-bit counter or as two separate 16-bit halves. In 16-bit mode physical counter p serves as logical counter p through its upper half and as logical counter p+4 through its lower half, so the bank provides eight logical counters. A shared vector of event inputs feeds the bank. Each logical counter has its own control word that enables it and picks one input from that vector. Counting takes place only while the global enable is set.

Software writes a counter value into a staging latch, and the live counter does not change. The latched values move into the live counters in one step on any control-register write that has the enable bit set. Such a write can turn the monitor on, or it can rewrite the control register while the monitor is already on. When a counter wraps and its interrupt-enable bit is set, the matching status bit goes high and the interrupt output asserts. A read of the status register returns the pending bits and clears them in the same access. Register data travels in bits 63:32 of the 64-bit bus word.

Top module: `split_ctr_bank`

## Requirements
- R1: Register data uses bits 63:32 of the bus word. Write bits 31:0 are ignored, and read-data bits 31:0 are always zero. Read data is zero whenever the read strobe is low.
- R2: A write to a logical counter (address 2+l) loads only the staging latch of its physical counter. The live value keeps counting and is not replaced until a commit.
- R3: A write to the control register (address 0) with bit 8 (enable) set copies every pending latch into its live counter at that edge and clears all pending flags. A control write with bit 8 clear commits nothing.
- R4: Each logical counter l has a control word at address 10+l, with bit 4 as its enable and bits 2:0 selecting the event input. It adds one for every cycle in which its selected input is high, its enable is set and the global enable is set.
- R5: When control bit p is 0, physical counter p counts as one 32-bit counter through logical counter p, wraps from 0xFFFFFFFF to 0 and ignores logical counter p+4. Reading logical p returns the full 32 bits.
- R6: When control bit p is 1, logical p counts in the upper 16 bits and logical p+4 counts in the lower 16 bits. Each half wraps at 0xFFFF on its own, with no carry between them. Reading logical p returns the upper half zero-extended. Reading logical p+4 returns the lower half zero-extended in either mode.
- R7: A 16-bit write updates one half of the latch. The other half is taken from the latch if a write to that physical counter is still pending, and from the live value otherwise. In 32-bit mode a write to logical p loads all 32 bits.
- R8: Writing the status register (address 1) sets the 8-bit interrupt mask. An overflow sets status bit p (32-bit wrap or upper-half wrap) or bit p+4 (lower-half wrap) only when that mask bit is set. A commit into a counter suppresses that counter's overflow in the same cycle.
- R9: The interrupt output is high while any status bit is pending. A status read returns the pending bits and clears them, except that a bit set in the same cycle survives.
- R10: The control register and the counter-control words are write-only and read as zero. Unused addresses also read as zero.
- R11: After a synchronous reset, all counters, latches, pending flags, control fields, the mask and the status are zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Word address |
| wr_data_i | input | 64 | Write data, register in bits 63:32 |
| rd_data_o | output | 64 | Read data, register in bits 63:32 |
| evt_i | input | 8 | Event inputs |
| irq_o | output | 1 | Counter overflow interrupt |

## Verification
Read data is combinational, so a value can be checked in the same cycle that the read strobe is raised. The clear that a status read causes shows up from the next cycle. A counter write, a commit, an event increment or an overflow takes effect at the next rising edge, and its result, including the interrupt, is visible immediately after that edge. The bench drives inputs one time unit after each rising edge and advances its reference model at the rising edge. It compares read data and the interrupt against the model at every falling edge, so each result is checked in the first cycle it is due and in every cycle after.

// File: rtl/split_ctr_pkg.sv
package split_ctr_pkg;

    localparam int DEF_NUM_PHYS = 4;
    localparam int DEF_NUM_EVT  = 8;
    localparam int DEF_ADDR_W   = 5;
    localparam int BUS_W        = 64;
    localparam int REG_W        = 32;

    // field positions inside the 32-bit register payload
    localparam int CTL_EN_BIT   = 8;
    localparam int CCTL_EN_BIT  = 4;
    localparam int CNT_ADDR0    = 2;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_STAT,
        REG_CNT,
        REG_CCTL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [7:0] a, input int nlog);
        reg_sel_t s;
        s.kind = REG_NONE;
        s.idx  = 8'd0;
        if (a == 8'd0) begin
            s.kind = REG_CTRL;
        end else if (a == 8'd1) begin
            s.kind = REG_STAT;
        end else if (a < 8'(CNT_ADDR0 + nlog)) begin
            s.kind = REG_CNT;
            s.idx  = a - 8'(CNT_ADDR0);
        end else if (a < 8'(CNT_ADDR0 + 2 * nlog)) begin
            s.kind = REG_CCTL;
            s.idx  = a - 8'(CNT_ADDR0 + nlog);
        end
        return s;
    endfunction

endpackage

// File: rtl/split_ctr_evt.sv
module split_ctr_evt #(
    parameter int NUM_EVT = 8,
    localparam int SEL_W  = $clog2(NUM_EVT)
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               en_i,
    input  logic               gen_i,
    output logic               hit_o
);
    assign hit_o = gen_i && en_i && evt_i[sel_i];
endmodule

// File: rtl/split_ctr_phys.sv
module split_ctr_phys #(
    parameter int CNT_W = 32,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             mode16_i,
    input  logic             cnt_a_i,
    input  logic             cnt_b_i,
    input  logic             commit_i,
    input  logic             ld_full_i,
    input  logic             ld_hi_i,
    input  logic             ld_lo_i,
    input  logic [CNT_W-1:0] ld_data_i,
    output logic [CNT_W-1:0] live_o,
    output logic             ovf_a_o,
    output logic             ovf_b_o
);
    logic [CNT_W-1:0] live_q, latch_q, live_d, base;
    logic             pend_q, take, hi_max, lo_max;

    assign take   = commit_i && pend_q;
    assign base   = pend_q ? latch_q : live_q;
    assign hi_max = &live_q[CNT_W-1:HALF_W];
    assign lo_max = &live_q[HALF_W-1:0];

    always_comb begin
        if (take) begin
            live_d = latch_q;
        end else if (mode16_i) begin
            live_d = {live_q[CNT_W-1:HALF_W] + HALF_W'(cnt_a_i),
                      live_q[HALF_W-1:0]     + HALF_W'(cnt_b_i)};
        end else begin
            live_d = live_q + CNT_W'(cnt_a_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            live_q  <= '0;
            latch_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            live_q <= live_d;
            if (ld_full_i) begin
                latch_q <= ld_data_i;
            end else if (ld_hi_i) begin
                latch_q <= {ld_data_i[HALF_W-1:0], base[HALF_W-1:0]};
            end else if (ld_lo_i) begin
                latch_q <= {base[CNT_W-1:HALF_W], ld_data_i[HALF_W-1:0]};
            end
            if (ld_full_i || ld_hi_i || ld_lo_i) begin
                pend_q <= 1'b1;
            end else if (commit_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign live_o  = live_q;
    assign ovf_a_o = !take && cnt_a_i && (mode16_i ? hi_max : (hi_max && lo_max));
    assign ovf_b_o = !take && mode16_i && cnt_b_i && lo_max;

    AST_LATCH_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        (ld_full_i || ld_hi_i || ld_lo_i) && !commit_i && !cnt_a_i && !cnt_b_i |=> $stable(live_q)); // R2
    AST_COMMIT_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_i && pend_q |=> live_q == $past(latch_q)); // R3
    AST_NO_HALF_CARRY: assert property (@(posedge clk_i) disable iff (rst_i)
        mode16_i && !cnt_a_i && !(commit_i && pend_q) |=> live_q[CNT_W-1:HALF_W] == $past(live_q[CNT_W-1:HALF_W])); // R6
endmodule

// File: rtl/split_ctr_status.sv
module split_ctr_status #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] pend_o,
    output logic         irq_o
);
    logic [N-1:0] pend_q, mask_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            if (mask_wr_i) mask_q <= mask_i;
            pend_q <= (clr_i ? '0 : pend_q) | (set_i & mask_q);
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = |pend_q;

    AST_MASKED_SET: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((pend_q & ~$past(pend_q)) & ~$past(mask_q)) == '0); // R8
    AST_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i && !(|(set_i & mask_q)) |=> pend_q == '0); // R9
endmodule

// File: rtl/split_ctr_bank.sv
module split_ctr_bank
    import split_ctr_pkg::*;
#(
    parameter int NUM_PHYS = DEF_NUM_PHYS,
    parameter int NUM_EVT  = DEF_NUM_EVT,
    parameter int ADDR_W   = DEF_ADDR_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BUS_W-1:0]   wr_data_i,
    output logic [BUS_W-1:0]   rd_data_o,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o
);
    localparam int NUM_LOG = 2 * NUM_PHYS;
    localparam int CNT_W   = REG_W;
    localparam int HALF_W  = CNT_W / 2;
    localparam int SEL_W   = $clog2(NUM_EVT);

    logic [REG_W-1:0]    wd, rval;
    reg_sel_t            sel;
    logic                gen_q, commit;
    logic [NUM_PHYS-1:0] mode_q;
    logic                cc_en_q  [NUM_LOG];
    logic [SEL_W-1:0]    cc_sel_q [NUM_LOG];
    logic [NUM_LOG-1:0]  hit, ovf, pend;
    logic [CNT_W-1:0]    live [NUM_PHYS];

    assign wd     = wr_data_i[BUS_W-1:BUS_W-REG_W];
    assign sel    = decode_addr(8'(addr_i), NUM_LOG);
    assign commit = wr_en_i && sel.kind == REG_CTRL && wd[CTL_EN_BIT];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gen_q  <= 1'b0;
            mode_q <= '0;
            for (int l = 0; l < NUM_LOG; l++) begin
                cc_en_q[l]  <= 1'b0;
                cc_sel_q[l] <= '0;
            end
        end else if (wr_en_i) begin
            if (sel.kind == REG_CTRL) begin
                gen_q  <= wd[CTL_EN_BIT];
                mode_q <= wd[NUM_PHYS-1:0];
            end
            for (int l = 0; l < NUM_LOG; l++) begin
                if (sel.kind == REG_CCTL && sel.idx == 8'(l)) begin
                    cc_en_q[l]  <= wd[CCTL_EN_BIT];
                    cc_sel_q[l] <= wd[SEL_W-1:0];
                end
            end
        end
    end

    for (genvar l = 0; l < NUM_LOG; l++) begin : g_log
        split_ctr_evt #(.NUM_EVT(NUM_EVT)) u_evt (
            .evt_i (evt_i),
            .sel_i (cc_sel_q[l]),
            .en_i  (cc_en_q[l]),
            .gen_i (gen_q),
            .hit_o (hit[l])
        );
    end

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
        logic wr_a, wr_b;
        assign wr_a = wr_en_i && sel.kind == REG_CNT && sel.idx == 8'(p);
        assign wr_b = wr_en_i && sel.kind == REG_CNT && sel.idx == 8'(p + NUM_PHYS);
        split_ctr_phys #(.CNT_W(CNT_W)) u_phys (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .mode16_i  (mode_q[p]),
            .cnt_a_i   (hit[p]),
            .cnt_b_i   (hit[p + NUM_PHYS]),
            .commit_i  (commit),
            .ld_full_i (wr_a && !mode_q[p]),
            .ld_hi_i   (wr_a && mode_q[p]),
            .ld_lo_i   (wr_b),
            .ld_data_i (wd),
            .live_o    (live[p]),
            .ovf_a_o   (ovf[p]),
            .ovf_b_o   (ovf[p + NUM_PHYS])
        );
    end

    split_ctr_status #(.N(NUM_LOG)) u_status (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mask_wr_i (wr_en_i && sel.kind == REG_STAT),
        .mask_i    (wd[NUM_LOG-1:0]),
        .set_i     (ovf),
        .clr_i     (rd_en_i && sel.kind == REG_STAT),
        .pend_o    (pend),
        .irq_o     (irq_o)
    );

    always_comb begin
        rval = '0;
        if (sel.kind == REG_STAT) begin
            rval = REG_W'(pend);
        end else if (sel.kind == REG_CNT) begin
            for (int p = 0; p < NUM_PHYS; p++) begin
                if (sel.idx == 8'(p)) begin
                    rval = mode_q[p] ? REG_W'(live[p][CNT_W-1:HALF_W]) : live[p];
                end
                if (sel.idx == 8'(p + NUM_PHYS)) begin
                    rval = REG_W'(live[p][HALF_W-1:0]);
                end
            end
        end
    end

    assign rd_data_o = rd_en_i ? {rval, {(BUS_W-REG_W){1'b0}}} : '0;

    AST_IDLE_LOW_WORD: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_data_o[BUS_W-REG_W-1:0] == '0 && (rd_en_i || rd_data_o == '0)); // R1
    AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i && (sel.kind == REG_CTRL || sel.kind == REG_CCTL || sel.kind == REG_NONE) |-> rd_data_o == '0); // R10
    AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !gen_q && !wr_en_i |=> $stable(live[0])); // R4
endmodule

// File: tb/test_split_ctr_bank.sv
module test_split_ctr_bank;
    localparam time CLK_PERIOD = 10;
    localparam int  NP = 4;
    localparam int  NL = 8;
    localparam int  NE = 8;

    logic          clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [63:0]   wdata = '0;
    logic [NE-1:0] evt = '0;
    wire  [63:0]   rdata;
    wire           irq;

    int    errors = 0, checks = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    logic [31:0] m_live [NP];
    logic [31:0] m_latch[NP];
    bit          m_pend [NP];
    bit          m_en;
    bit [NP-1:0] m_mode;
    bit          m_cen  [NL];
    int          m_csel [NL];
    bit [7:0]    m_mask, m_stat;

    split_ctr_bank i_split_ctr_bank (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
        .evt_i(evt), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function void model_step();
        logic [31:0] wd, old_live[NP], base;
        logic [15:0] hi, lo;
        bit          hit[NL];
        bit [7:0]    ovf;
        bit          commit;
        int          a, l, p;
        if (rst) begin
            for (int i = 0; i < NP; i++) begin
                m_live[i] = 0; m_latch[i] = 0; m_pend[i] = 0;
            end
            for (int i = 0; i < NL; i++) begin
                m_cen[i] = 0; m_csel[i] = 0;
            end
            m_en = 0; m_mode = 0; m_mask = 0; m_stat = 0;
            return;
        end
        wd  = wdata[63:32];
        a   = int'(addr);
        ovf = 0;
        for (int i = 0; i < NL; i++) hit[i] = m_en && m_cen[i] && evt[m_csel[i]];
        commit = wr_en && a == 0 && wd[8];
        for (int i = 0; i < NP; i++) begin
            old_live[i] = m_live[i];
            if (commit && m_pend[i]) begin
                m_live[i] = m_latch[i];
            end else if (m_mode[i]) begin
                hi = m_live[i][31:16];
                lo = m_live[i][15:0];
                if (hit[i])      begin if (hi == 16'hFFFF) ovf[i] = 1;     hi = hi + 16'd1; end
                if (hit[i + NP]) begin if (lo == 16'hFFFF) ovf[i + NP] = 1; lo = lo + 16'd1; end
                m_live[i] = {hi, lo};
            end else if (hit[i]) begin
                if (m_live[i] == 32'hFFFF_FFFF) ovf[i] = 1;
                m_live[i] = m_live[i] + 32'd1;
            end
        end
        m_stat = ((rd_en && a == 1) ? 8'h00 : m_stat) | (ovf & m_mask);
        if (wr_en) begin
            if (a == 0) begin
                m_mode = wd[3:0];
                m_en   = wd[8];
                if (commit) for (int i = 0; i < NP; i++) m_pend[i] = 0;
            end else if (a == 1) begin
                m_mask = wd[7:0];
            end else if (a >= 2 && a < 2 + NL) begin
                l = a - 2;
                p = l % NP;
                base = m_pend[p] ? m_latch[p] : old_live[p];
                if (l < NP && !m_mode[p]) m_latch[p] = wd;
                else if (l < NP)          m_latch[p] = {wd[15:0], base[15:0]};
                else                      m_latch[p] = {base[31:16], wd[15:0]};
                m_pend[p] = 1;
            end else if (a >= 2 + NL && a < 2 + 2 * NL) begin
                l = a - 2 - NL;
                m_cen[l]  = wd[4];
                m_csel[l] = int'(wd[2:0]);
            end
        end
    endfunction

    function logic [63:0] exp_read();
        logic [31:0] v;
        int a, l, p;
        v = 0;
        a = int'(addr);
        if (!rd_en) return 64'h0;
        if (a == 1) v = {24'h0, m_stat};
        else if (a >= 2 && a < 2 + NL) begin
            l = a - 2;
            p = l % NP;
            if (l < NP) v = m_mode[p] ? {16'h0, m_live[p][31:16]} : m_live[p];
            else        v = {16'h0, m_live[p][15:0]};
        end
        return {v, 32'h0};
    endfunction

    always @(posedge clk) model_step();

    always @(negedge clk) begin
        if (!done) begin
            logic [63:0] e;
            e = exp_read();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s read addr=%0d: actual=%h expected=%h", cur_req, addr, rdata, e);
            end
            checks++;
            if (irq !== (m_stat != 0)) begin
                errors++;
                $display("FAIL %s irq: actual=%b expected=%b", cur_req, irq, m_stat != 0);
            end
        end
    end

    task automatic wr_reg(input int a, input logic [31:0] v);
        @(posedge clk); #1;
        wr_en = 1; rd_en = 0; addr = 5'(a); wdata = {v, 32'h5A5A_A5A5};
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd_reg(input int a);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 1; addr = 5'(a);
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            wr_en = 0; rd_en = 0;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cur_req = "R11"; rd_reg(1); rd_reg(2); rd_reg(9);
        cur_req = "R10"; rd_reg(0); rd_reg(10); rd_reg(17); rd_reg(31);
        cur_req = "R8";  wr_reg(1, 32'hFF);
        cur_req = "R4";
        wr_reg(10, 32'h10); wr_reg(14, 32'h11); wr_reg(11, 32'h12); wr_reg(15, 32'h13);
        evt = 8'hFF; idle(5); rd_reg(2);
        cur_req = "R2"; wr_reg(2, 32'hFFFF_FFF0); rd_reg(2); idle(2); rd_reg(2);
        cur_req = "R3"; wr_reg(0, 32'h0); rd_reg(2); wr_reg(0, 32'h100); rd_reg(2);
        cur_req = "R5"; evt = 8'h01;
        for (int i = 0; i < 12; i++) rd_reg(2);
        rd_reg(6);
        cur_req = "R9"; rd_reg(1); rd_reg(1);
        cur_req = "R6"; wr_reg(0, 32'h102); wr_reg(3, 32'h0000_FFF0);
        cur_req = "R7"; wr_reg(7, 32'h0000_FFF8); rd_reg(3); wr_reg(0, 32'h102);
        cur_req = "R6"; evt = 8'h0C;
        for (int i = 0; i < 8; i++) begin rd_reg(3); rd_reg(7); rd_reg(1); end
        cur_req = "R7"; evt = 8'h00; wr_reg(7, 32'h1234); wr_reg(0, 32'h102); rd_reg(3); rd_reg(7);
        cur_req = "R8"; wr_reg(1, 32'h0); wr_reg(2, 32'hFFFF_FFFE); wr_reg(0, 32'h102);
        evt = 8'h01; idle(6); rd_reg(1); rd_reg(2);
        cur_req = "R4"; wr_reg(1, 32'hFF); wr_reg(0, 32'h2); idle(4); rd_reg(2); rd_reg(3);
        cur_req = "R1"; lf = 16'hACE1; wr_reg(0, 32'h10F);
        for (int i = 0; i < 300; i++) begin
            lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            evt = lf[7:0];
            if (lf[2:0] == 3'd0)      wr_reg(0, {23'h0, lf[12], 4'h0, lf[3:0]});
            else if (lf[2:0] == 3'd1) wr_reg(2 + int'(lf[13:11]), {lf, lf ^ 16'hF00F});
            else if (lf[2:0] == 3'd2) wr_reg(1, {24'h0, lf[15:8]});
            else                      rd_reg(int'(lf[15:11]) % 18);
        end
        idle(2);
        finish_run();
    end
endmodule